// File: doc/BRIEF.md
# Two-Wire EEPROM Random-Read Master

This block fetches a single byte from a two-wire serial EEPROM at a 16-bit word address. It drives the clock line, the data line and the data driver enable, and it samples the data line back. One request runs the whole sequence:

- a start condition;
- a dummy write made of the device write code and both address bytes, each one acknowledged by the memory;
- a repeated start;
- the device read code, also acknowledged;
- eight data bits clocked in from the memory;
- a stop condition.

The result is either the byte that was read or an error flag. The error is raised when any acknowledge is missing. In that case the sequence goes directly to the stop.

Every change on the output lines is followed by a hold time. The hold is set by the cycle-count parameter `STEP_CYCLES`, which would normally equal the number of system clocks in about one microsecond. Acknowledge samples are taken in a single cycle and add no hold time. The requester pulses `start` with an address and then waits for the one-cycle `done` pulse. While `busy` is high, further `start` pulses are ignored.

Top module: `ee_rand_reader`

## Requirements
- R1: After reset the outputs are: `busy`=0, `done`=0, `scl_o`=0, `sda_o`=1, `sda_oe_o`=0, `rd_data`=0x00 and `err`=0.
- R2: A start condition raises data with the driver enabled, raises the clock, and then lowers data while the clock is high. A successful read contains exactly two such falling data edges: the first start and the repeated start after the low address byte.
- R3: The bytes sent are, in order: 0xA0, `addr[15:8]`, `addr[7:0]`, then 0xA1 after the repeated start. Each byte goes out most significant bit first. Outside start and stop, the data line changes only while the clock is low.
- R4: After each sent byte the master drives data low, disables its driver, and gives a ninth clock pulse. It samples `sda_i` while the clock is high. The driver enable stays 0 for that whole pulse, and a sample of 1 counts as a missing acknowledge.
- R5: The data byte is read over eight clock pulses with the driver disabled. `sda_i` is sampled while the clock is high and the byte is built MSB first. No acknowledge pulse follows, so a successful read has exactly 47 rising clock edges.
- R6: Every request ends with exactly one stop condition: data rises while the clock is high, with the driver enabled.
- R7: A missing acknowledge on sent byte k (k = 0 to 3) sends the sequence directly to the stop. No further byte is sent. The result is `err`=1 and `rd_data`=0x00, and the clock has 1 + 9(k+1) + (1 if k=3) + 1 rising edges. A successful read gives `err`=0.
- R8: Each step that changes a line holds all lines steady for exactly `STEP_CYCLES`+1 clock cycles before the next step.
- R9: `done` is high for exactly one cycle. `busy` is low in that same cycle, and `busy` falls only together with `done`.
- R10: A `start` pulse while `busy` is high is ignored. The running read keeps its address, and no second request begins.
- R11: Take the edge that accepts `start` as edge 0. `done` rises at edge 1 + L(`STEP_CYCLES`+1) + S, where L counts line steps and S counts sample steps. A successful read has L=151 and S=12. A missing acknowledge on byte k has L = 10 + 30(k+1) + (5 if k=3) and S = k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request pulse, taken only while idle |
| addr | input | 16 | EEPROM word address, captured with `start` |
| busy | output | 1 | High while a request is running |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read, or 0x00 after an error; held until the next `done` |
| err | output | 1 | Missing-acknowledge result; held until the next `done` |
| scl_o | output | 1 | Serial clock level |
| sda_o | output | 1 | Serial data level driven when enabled |
| sda_oe_o | output | 1 | Serial data driver enable |
| sda_i | input | 1 | Serial data line as seen on the bus |

## Verification
The result is due exactly 1 + L(`STEP_CYCLES`+1) + S edges after the accepting edge. L and S are computed in the bench for the success case and for a missing acknowledge on each byte. The bench counts falling clock edges from the one that follows the accepting edge, so the count where `done` is first seen must equal that figure plus one. The bus itself is checked by an event-driven memory model that reacts to `scl_o` edges. It records the bytes, the start and stop conditions, the rising clock edges and any driver enable during the acknowledge and read pulses. A line monitor sampled on the falling clock edge measures the smallest spacing between line changes. `done`, `busy`, `rd_data` and `err` are all sampled on falling edges, half a period after the registers update.

// File: rtl/ee_rr_pkg.sv
package ee_rr_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_PRE, PH_BIT, PH_ACK, PH_RSTART, PH_READ, PH_STOP, PH_FIN
  } phase_e;

  typedef enum logic [2:0] {OP_NOP, OP_CLK, OP_DO, OP_OE, OP_SMP} opk_e;

  typedef struct packed {
    opk_e kind;
    logic val;
    logic last;
  } op_t;

  localparam logic [7:0] DEV_WR = 8'hA0;
  localparam logic [7:0] DEV_RD = 8'hA1;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/ee_rr_rst_sync.sv
module ee_rr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ee_rr_timer.sv
module ee_rr_timer #(
  parameter int unsigned STEP = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic ready
);
  localparam int unsigned CW = $clog2(STEP + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign ready  = (cnt_q == '0);
  assign cnt_en = load || !ready;

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = CW'(STEP);
    else if (!ready) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ee_rr_opdec.sv
module ee_rr_opdec
  import ee_rr_pkg::*;
(
  input  phase_e     phase,
  input  logic [2:0] sub,
  input  logic       txbit,
  output op_t        op
);
  function automatic op_t mk(opk_e k, logic v, logic l);
    op_t o;
    o.kind = k;
    o.val  = v;
    o.last = l;
    return o;
  endfunction

  always_comb begin
    op = mk(OP_NOP, 1'b0, 1'b1);
    case (phase)
      PH_START, PH_RSTART: begin
        case (sub)
          3'd0:    op = mk(OP_DO,  1'b1, 1'b0);
          3'd1:    op = mk(OP_OE,  1'b1, 1'b0);
          3'd2:    op = mk(OP_CLK, 1'b1, 1'b0);
          3'd3:    op = mk(OP_DO,  1'b0, 1'b0);
          default: op = mk(OP_CLK, 1'b0, 1'b1);
        endcase
      end
      PH_PRE: begin
        if (sub == 3'd0) op = mk(OP_DO, 1'b0, 1'b0);
        else             op = mk(OP_OE, 1'b1, 1'b1);
      end
      PH_BIT: begin
        case (sub)
          3'd0:    op = mk(OP_DO,  txbit, 1'b0);
          3'd1:    op = mk(OP_CLK, 1'b1,  1'b0);
          default: op = mk(OP_CLK, 1'b0,  1'b1);
        endcase
      end
      PH_ACK: begin
        case (sub)
          3'd0:    op = mk(OP_DO,  1'b0, 1'b0);
          3'd1:    op = mk(OP_OE,  1'b0, 1'b0);
          3'd2:    op = mk(OP_CLK, 1'b1, 1'b0);
          3'd3:    op = mk(OP_SMP, 1'b0, 1'b0);
          default: op = mk(OP_CLK, 1'b0, 1'b1);
        endcase
      end
      PH_READ: begin
        case (sub)
          3'd0:    op = mk(OP_CLK, 1'b1, 1'b0);
          3'd1:    op = mk(OP_SMP, 1'b0, 1'b0);
          default: op = mk(OP_CLK, 1'b0, 1'b1);
        endcase
      end
      PH_STOP: begin
        case (sub)
          3'd0:    op = mk(OP_DO,  1'b0, 1'b0);
          3'd1:    op = mk(OP_OE,  1'b1, 1'b0);
          3'd2:    op = mk(OP_CLK, 1'b1, 1'b0);
          3'd3:    op = mk(OP_DO,  1'b1, 1'b0);
          default: op = mk(OP_CLK, 1'b0, 1'b1);
        endcase
      end
      default: op = mk(OP_NOP, 1'b0, 1'b1);
    endcase
  end
endmodule

// File: rtl/ee_rand_reader.sv
module ee_rand_reader
  import ee_rr_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rd_data,
  output logic              err,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  logic              rst_sync_n;
  logic              ready, exec, load, txbit;
  op_t               op;
  logic [BYTE_W-1:0] tx_byte;

  phase_e            phase_q, phase_d;
  logic [2:0]        sub_q, sub_d, bitn_q, bitn_d;
  logic [1:0]        byten_q, byten_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] sh_q, sh_d, rdata_q, rdata_d;
  logic              nak_q, nak_d, err_q, err_d, done_q, done_d;
  logic              scl_q, scl_d, sdo_q, sdo_d, soe_q, soe_d;

  ee_rr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  ee_rr_timer #(.STEP(STEP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .ready(ready)
  );

  ee_rr_opdec u_dec (.phase(phase_q), .sub(sub_q), .txbit(txbit), .op(op));

  always_comb begin
    case (byten_q)
      2'd0:    tx_byte = DEV_WR;
      2'd1:    tx_byte = addr_q[15:8];
      2'd2:    tx_byte = addr_q[7:0];
      default: tx_byte = DEV_RD;
    endcase
  end

  assign txbit = tx_byte[bitn_q];
  assign exec  = (phase_q != PH_IDLE) && ready;
  assign load  = exec && (op.kind == OP_CLK || op.kind == OP_DO || op.kind == OP_OE);

  always_comb begin
    phase_d = phase_q;  sub_d = sub_q;     bitn_d = bitn_q;  byten_d = byten_q;
    addr_d  = addr_q;   sh_d  = sh_q;      rdata_d = rdata_q;
    nak_d   = nak_q;    err_d = err_q;     done_d = 1'b0;
    scl_d   = scl_q;    sdo_d = sdo_q;     soe_d = soe_q;

    if (phase_q == PH_IDLE) begin
      if (start) begin
        phase_d = PH_START;  sub_d = '0;  byten_d = '0;
        addr_d  = addr;      nak_d = 1'b0; sh_d = '0;
      end
    end else if (exec) begin
      case (op.kind)
        OP_CLK: scl_d = op.val;
        OP_DO:  sdo_d = op.val;
        OP_OE:  soe_d = op.val;
        OP_SMP: begin
          if (phase_q == PH_ACK) begin
            if (sda_i) nak_d = 1'b1;
          end else begin
            sh_d = {sh_q[BYTE_W-2:0], sda_i};
          end
        end
        default: ;
      endcase

      if (!op.last) begin
        sub_d = sub_q + 3'd1;
      end else begin
        sub_d = '0;
        case (phase_q)
          PH_START, PH_RSTART: phase_d = PH_PRE;
          PH_PRE: begin
            phase_d = PH_BIT;
            bitn_d  = 3'd7;
          end
          PH_BIT: begin
            if (bitn_q == 3'd0) phase_d = PH_ACK;
            else                bitn_d  = bitn_q - 3'd1;
          end
          PH_ACK: begin
            if (nak_q) begin
              phase_d = PH_STOP;
            end else if (byten_q == 2'd2) begin
              phase_d = PH_RSTART;
              byten_d = 2'd3;
            end else if (byten_q == 2'd3) begin
              phase_d = PH_READ;
              bitn_d  = 3'd7;
            end else begin
              phase_d = PH_PRE;
              byten_d = byten_q + 2'd1;
            end
          end
          PH_READ: begin
            if (bitn_q == 3'd0) phase_d = PH_STOP;
            else                bitn_d  = bitn_q - 3'd1;
          end
          PH_STOP: phase_d = PH_FIN;
          default: begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
            err_d   = nak_q;
            rdata_d = nak_q ? '0 : sh_q;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_IDLE;  sub_q <= '0;  bitn_q <= '0;  byten_q <= '0;
      addr_q  <= '0;       sh_q  <= '0;  rdata_q <= '0;
      nak_q   <= 1'b0;     err_q <= 1'b0; done_q <= 1'b0;
      scl_q   <= 1'b0;     sdo_q <= 1'b1; soe_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;  sub_q <= sub_d;  bitn_q <= bitn_d;  byten_q <= byten_d;
      addr_q  <= addr_d;   sh_q  <= sh_d;   rdata_q <= rdata_d;
      nak_q   <= nak_d;    err_q <= err_d;  done_q <= done_d;
      scl_q   <= scl_d;    sdo_q <= sdo_d;  soe_q  <= soe_d;
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign rd_data  = rdata_q;
  assign err      = err_q;
  assign scl_o    = scl_q;
  assign sda_o    = sdo_q;
  assign sda_oe_o = soe_q;
endmodule

// File: rtl/ee_rr_chk.sv
module ee_rr_chk
  import ee_rr_pkg::*;
#(
  parameter int unsigned STEP = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [7:0] rd_data,
  input logic       scl,
  input logic       sdo,
  input logic       soe,
  input phase_e     phase
);
  logic [2:0]  prev_q;
  logic [31:0] gap_q;
  logic        chg;

  assign chg = ({scl, sdo, soe} != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 3'b010;
      gap_q  <= '1;
    end else begin
      prev_q <= {scl, sdo, soe};
      if (chg)              gap_q <= 32'd1;
      else if (gap_q != '1) gap_q <= gap_q + 32'd1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (gap_q >= STEP));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_sda_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && soe && !$stable(sdo))
      |-> (phase == PH_START || phase == PH_RSTART || phase == PH_STOP));

  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACK && scl) |-> !soe);

  assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == 8'h00));
endmodule

bind ee_rand_reader ee_rr_chk #(.STEP(STEP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .busy(busy), .done(done), .err(err),
  .rd_data(rd_data), .scl(scl_o), .sdo(sda_o), .soe(sda_oe_o), .phase(phase_q)
);

// File: tb/tb_ee_rand_reader.sv
module tb_ee_rand_reader;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        start = 1'b0;
  logic [15:0] addr_in = 16'h0000;
  logic        busy, done, err, scl, sda_o, sda_oe, sda_i;
  logic [7:0]  rd_data;
  logic        s_low = 1'b0;
  wire         bus = !((sda_oe && !sda_o) || s_low);
  assign sda_i = bus;

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_rand_reader #(.STEP_CYCLES(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr_in), .busy(busy),
    .done(done), .rd_data(rd_data), .err(err), .scl_o(scl), .sda_o(sda_o),
    .sda_oe_o(sda_oe), .sda_i(sda_i)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[15:8] * 8'd3) ^ a[7:0] ^ 8'h5A;
  endfunction

  // memory model on the bus
  int bc = 0, gidx = 0, nak_at = 9;
  int starts = 0, stops = 0, rises = 0, viol_ack = 0, viol_rd = 0;
  logic rd = 1'b0;
  logic [7:0] sh = 8'h00, rdbyte = 8'h00;
  logic [7:0] rxb [0:7];

  always @(negedge bus) if (scl === 1'b1) begin
    starts++; bc = 0; rd = 1'b0; s_low = 1'b0;
  end

  always @(posedge bus) if (scl === 1'b1) stops++;

  always @(posedge scl) begin
    rises++;
    if (rd) begin
      if (sda_oe) viol_rd++;
      bc++;
    end else if (bc < 8) begin
      sh = {sh[6:0], bus};
      bc++;
    end else if (bc == 8) begin
      if (sda_oe) viol_ack++;
      bc = 9;
    end
  end

  always @(negedge scl) begin
    if (rd) begin
      if (bc < 8) s_low = !rdbyte[7-bc];
      else begin s_low = 1'b0; rd = 1'b0; bc = 0; end
    end else if (bc == 8) begin
      if (gidx < 8) rxb[gidx] = sh;
      s_low = (gidx != nak_at);
    end else if (bc == 9) begin
      s_low = 1'b0;
      bc = 0;
      if (gidx == 3 && sh == 8'hA1 && gidx != nak_at) begin
        rd = 1'b1;
        rdbyte = memf({rxb[1], rxb[2]});
        s_low = !rdbyte[7];
      end
      gidx++;
    end
  end

  // line spacing monitor
  logic [2:0] prev_l = 3'bxxx;
  int gap = 1000000, min_gap = 1000000;
  always @(negedge clk) begin
    if ({scl, sda_o, sda_oe} !== prev_l) begin
      if (gap < min_gap) min_gap = gap;
      gap = 1;
    end else begin
      gap++;
    end
    prev_l = {scl, sda_o, sda_oe};
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic txn(input logic [15:0] a, input int nk, input logic poke);
    int n, exp_n, l_st, s_st, exp_rises, exp_starts;
    logic ok_done;
    bc = 0; gidx = 0; rd = 1'b0; s_low = 1'b0; nak_at = nk;
    starts = 0; stops = 0; rises = 0; viol_ack = 0; viol_rd = 0;
    for (int i = 0; i < 8; i++) rxb[i] = 8'h00;
    @(negedge clk);
    start = 1'b1;
    addr_in = a;
    n = 0;
    ok_done = 1'b0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 40) begin start = 1'b1; addr_in = ~a; end
      else begin start = 1'b0; addr_in = a; end
      if (done) begin ok_done = 1'b1; break; end
    end
    chk(ok_done, "R11", "done seen", int'(ok_done), 1);
    chk(busy == 1'b0, "R9", "busy low with done", int'(busy), 0);

    if (nk > 3) begin
      l_st = 151; s_st = 12; exp_rises = 47; exp_starts = 2;
    end else begin
      l_st = 10 + 30*(nk+1) + ((nk == 3) ? 5 : 0);
      s_st = nk + 1;
      exp_rises = 1 + 9*(nk+1) + ((nk == 3) ? 1 : 0) + 1;
      exp_starts = (nk == 3) ? 2 : 1;
    end
    exp_n = 2 + l_st*(STEP+1) + s_st;
    chk(n == exp_n, "R11", "done latency", n, exp_n);
    chk(rises == exp_rises, (nk > 3) ? "R5" : "R7", "clock rises", rises, exp_rises);
    chk(starts == exp_starts, "R2", "start conditions", starts, exp_starts);
    chk(stops == 1, "R6", "stop conditions", stops, 1);
    chk(viol_ack == 0, "R4", "driver on during ack", viol_ack, 0);
    chk(rxb[0] == 8'hA0, "R3", "device write code", int'(rxb[0]), 8'hA0);
    if (nk > 0) chk(rxb[1] == a[15:8], "R3", "address high", int'(rxb[1]), int'(a[15:8]));
    if (nk > 1) chk(rxb[2] == a[7:0], "R3", "address low", int'(rxb[2]), int'(a[7:0]));
    if (nk > 3) begin
      chk(rxb[3] == 8'hA1, "R3", "device read code", int'(rxb[3]), 8'hA1);
      chk(viol_rd == 0, "R5", "driver on during read", viol_rd, 0);
      chk(rd_data == memf(a), "R5", "read data", int'(rd_data), int'(memf(a)));
      chk(err == 1'b0, "R7", "err on success", int'(err), 0);
    end else begin
      chk(err == 1'b1, "R7", "err on nak", int'(err), 1);
      chk(rd_data == 8'h00, "R7", "data on nak", int'(rd_data), 0);
      chk(gidx == nk + 1, "R7", "bytes sent before stop", gidx, nk + 1);
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10", "no second request", int'(busy), 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(done == 1'b0, "R1", "done", int'(done), 0);
    chk(scl == 1'b0, "R1", "scl", int'(scl), 0);
    chk(sda_o == 1'b1, "R1", "sda_o", int'(sda_o), 1);
    chk(sda_oe == 1'b0, "R1", "sda_oe", int'(sda_oe), 0);
    chk(rd_data == 8'h00, "R1", "rd_data", int'(rd_data), 0);
    chk(err == 1'b0, "R1", "err", int'(err), 0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      a = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (16'(i) * 16'h2B47) ^ 16'h8001;
      txn(a, 9, 1'b0);
    end
    for (int k = 0; k < 4; k++) begin
      txn(16'h5AC3 + 16'(k), k, 1'b0);
      txn(16'hA53C - 16'(k), k, 1'b0);
    end
    txn(16'h1234, 9, 1'b1);   // R10: start pulse mid-request
    txn(16'h0F0F, 9, 1'b0);   // success right after an error-free poke run

    chk(min_gap == STEP + 1, "R8", "minimum line spacing", min_gap, STEP + 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule